// File: doc/BRIEF.md
# Framebuffer Scanout Controller

This block scans a fixed-size true-color image out of system memory and drives a TFT or VGA style pixel stream. It generates the raster timing (horizontal and vertical sync, both active low, and a data-enable strobe). It issues one word read per displayed pixel on a simple in-order memory read port, and unpacks each returned 32-bit word into 8-bit red, green and blue outputs. With default parameters the visible area is 640 by 480, inside an 800 by 525 total frame.

Software programs two 32-bit registers. One holds the frame base address, of which only the top 11 bits count, so a frame starts on a 2 MiB boundary. The other is a control word with an enable bit and a bit that rotates the picture by 180 degrees. Each row of the image sits at a fixed stride of 1024 words, and only the first 640 words of a row are ever read.

A base or rotation change, or turning the display on, waits for the next frame start, so a frame is never torn. Turning the display off takes effect at once. A small prefetch FIFO sits between memory and the pixel clock. Fetching for a row starts in the horizontal blanking that comes just before that row's pixels.

Top module: `fbscan_top`

## Requirements
- R1: After reset `deOut` is 0, `hsyncN` and `vsyncN` are 1, all color outputs are 0, `memReq` is 0 and the display is off.
- R2: Each line lasts H_FP+H_SYNC+H_BP+H_VIS clocks. Counted from line start it has H_FP front-porch clocks, H_SYNC clocks with `hsyncN` low, H_BP back-porch clocks, then H_VIS visible clocks. All outputs are registered one clock after the raster counters.
- R3: Each frame has V_VIS visible lines, then V_FP lines, then V_SYNC lines with `vsyncN` low, then V_BP lines.
- R4: `deOut` is 1 exactly in visible clocks of visible lines. Red, green and blue are 0 whenever `deOut` is 0.
- R5: A pixel word maps bits 23:16 to red, 15:8 to green and 7:0 to blue. Bits 31:24 are ignored.
- R6: Screen pixel (x, y) is read from word address B + y*ROW_STRIDE + x, where B is the frame base. Requests for a row go in ascending x, and only x below H_VIS is ever requested.
- R7: With control bit 1 set, screen pixel (x, y) shows the word of pixel (H_VIS-1-x, V_VIS-1-y), and requests within a row go in descending address order.
- R8: A write with `regSel`=0 sets the base. Only byte-address bits 31:21 are kept, giving word base {regWdata[31:21], 19 zero bits}. A write with `regSel`=1 sets the control word: bit 0 is enable and bit 1 is rotate.
- R9: A new base, a new rotate value, or enable going to 1 is applied at the frame boundary, on the clock where both raster counters wrap. Writing enable 0 forces colors to 0 and stops requests from the second clock after the write.
- R10: While the display is off no read request is raised, and the syncs and `deOut` keep their timing.
- R11: A request not yet accepted keeps its address. Read data is taken in request order. The prefetch FIFO never holds more than FIFO_DEPTH words.
- R12: The requests for visible line y are issued in that same line, starting during its blanking part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 base, 1 control |
| regWdata | input | 32 | Register write data |
| memReq | output | 1 | Read request |
| memAddr | output | WORD_AW | Word address of the request |
| memReady | input | 1 | Memory accepts the request this clock |
| memRdValid | input | 1 | Read data valid, in request order |
| memRdData | input | 32 | Read data word |
| deOut | output | 1 | Data enable, high in the visible area |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The scanout is run with an address-derived pixel pattern that sets all four bytes of each word, so a wrong byte lane, a wrong column or a wrong row each show up as a color mismatch. Frames are run unrotated and rotated, with base writes whose low bits are non-zero. Register writes land in the middle of a row, which separates settings applied at the frame boundary from settings applied at once. A disable in mid-row followed by a re-enable exercises the flush and the dropping of in-flight data. Memory readiness and latency are random with a fixed seed, and each accepted address is compared with the next expected word of the current line.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  // strobes from the raster control to the fetch datapath
  typedef struct packed {
    logic rowStart;  // first clock of a visible line: arm the row fetch
    logic firstRow;  // qualifies rowStart for line 0 of the frame
    logic pixPop;    // visible clock while the display is active
    logic flush;     // display inactive: drop queued and in-flight data
  } fbscan_strobe_t;
endpackage

// File: rtl/fbscan_fifo.sv
module fbscan_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic [CNTW-1:0]  count,
  output logic             empty
);
  localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTRW-1:0]  wrPtr, rdPtr;

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  assign rdData = store[rdPtr];
  assign empty  = (count == '0);
endmodule

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int H_VIS = 640, H_FP = 16, H_SYNC = 96, H_BP = 48,
  parameter int V_VIS = 480, V_FP = 10, V_SYNC = 2,  V_BP = 33,
  parameter int WORD_AW = 30,
  parameter int BASE_BITS = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regSel,
  input  logic [31:0]        regWdata,
  output fbscan_strobe_t     strb,
  output logic [WORD_AW-1:0] frmBaseWord,
  output logic               frmRotate,
  output logic               deOut,
  output logic               hsyncN,
  output logic               vsyncN
);
  localparam int HBLANK = H_FP + H_SYNC + H_BP;
  localparam int HTOT   = HBLANK + H_VIS;
  localparam int VTOT   = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW    = $clog2(HTOT);
  localparam int VCW    = $clog2(VTOT);
  localparam int LOWW   = WORD_AW - BASE_BITS;
  localparam logic [HCW-1:0] H_LAST  = HCW'(HTOT - 1);
  localparam logic [HCW-1:0] H_VIS0  = HCW'(HBLANK);
  localparam logic [HCW-1:0] HS_ON   = HCW'(H_FP);
  localparam logic [HCW-1:0] HS_OFF  = HCW'(H_FP + H_SYNC);
  localparam logic [VCW-1:0] V_LAST  = VCW'(VTOT - 1);
  localparam logic [VCW-1:0] V_VISW  = VCW'(V_VIS);
  localparam logic [VCW-1:0] VS_ON   = VCW'(V_VIS + V_FP);
  localparam logic [VCW-1:0] VS_OFF  = VCW'(V_VIS + V_FP + V_SYNC);

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] vCnt;
  logic [BASE_BITS-1:0] cfgBase, frmBase;
  logic cfgEnable, cfgRotate, frmEnable;
  logic lineEnd, frameEnd, visLine, visible;
  logic [28-BASE_BITS:0] unusedWr;

  assign unusedWr = regWdata[30-BASE_BITS:2];

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = lineEnd && (vCnt == V_LAST);
  assign visLine  = (vCnt < V_VISW);
  assign visible  = visLine && (hCnt >= H_VIS0);

  // raster counters run whether or not the display is on
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // software view and the per-frame snapshot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBase   <= '0;
      cfgEnable <= 1'b0;
      cfgRotate <= 1'b0;
      frmBase   <= '0;
      frmEnable <= 1'b0;
      frmRotate <= 1'b0;
    end else begin
      if (regWe && !regSel) cfgBase <= regWdata[31 -: BASE_BITS];
      if (regWe && regSel) begin
        cfgEnable <= regWdata[0];
        cfgRotate <= regWdata[1];
      end
      if (frameEnd) begin
        frmBase   <= cfgBase;
        frmRotate <= cfgRotate;
        frmEnable <= cfgEnable;
      end else if (!cfgEnable) begin
        frmEnable <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deOut  <= 1'b0;
      hsyncN <= 1'b1;
      vsyncN <= 1'b1;
    end else begin
      deOut  <= visible;
      hsyncN <= !((hCnt >= HS_ON) && (hCnt < HS_OFF));
      vsyncN <= !((vCnt >= VS_ON) && (vCnt < VS_OFF));
    end
  end

  assign frmBaseWord   = {frmBase, {LOWW{1'b0}}};
  assign strb.rowStart = frmEnable && visLine && (hCnt == '0);
  assign strb.firstRow = (vCnt == '0);
  assign strb.pixPop   = frmEnable && visible;
  assign strb.flush    = !frmEnable;
endmodule

// File: rtl/fbscan_dp.sv
module fbscan_dp
  import fbscan_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int V_VIS = 480,
  parameter int ROW_STRIDE = 1024,
  parameter int WORD_AW = 30,
  parameter int FIFO_DEPTH = 16,
  localparam int CNTW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fbscan_strobe_t     strb,
  input  logic [WORD_AW-1:0] frmBaseWord,
  input  logic               frmRotate,
  output logic               memReq,
  output logic [WORD_AW-1:0] memAddr,
  input  logic               memReady,
  input  logic               memRdValid,
  input  logic [31:0]        memRdData,
  output logic [7:0]         red,
  output logic [7:0]         green,
  output logic [7:0]         blue,
  output logic [CNTW-1:0]    fifoCnt
);
  localparam int LW = $clog2(H_VIS + 1);
  localparam int PW = $clog2(2 * FIFO_DEPTH + 1);
  localparam int SW = PW + 1;
  localparam logic [LW-1:0]      ROW_WORDS  = LW'(H_VIS);
  localparam logic [WORD_AW-1:0] STRIDE_W   = WORD_AW'(ROW_STRIDE);
  localparam logic [WORD_AW-1:0] LAST_COL   = WORD_AW'(H_VIS - 1);
  localparam logic [WORD_AW-1:0] LAST_ROWOF = WORD_AW'((V_VIS - 1) * ROW_STRIDE);
  localparam logic [SW-1:0]      DEPTH_S    = SW'(FIFO_DEPTH);

  logic [WORD_AW-1:0] rowPtr, curAddr, thisRow;
  logic [LW-1:0] wordsLeft;
  logic [PW-1:0] pendKeep, pendDrop, keepNext, dropNext;
  logic credit, accept, rspKeep, rspDrop, fifoEmpty, popNow;
  logic [23:0] headPix, pixReg;
  logic [7:0] unusedTop;

  assign unusedTop = memRdData[31:24];

  // words queued plus words promised must fit the FIFO
  assign credit  = (SW'(fifoCnt) + SW'(pendKeep)) < DEPTH_S;
  assign memReq  = !strb.flush && (wordsLeft != '0) && credit;
  assign memAddr = curAddr;
  assign accept  = memReq && memReady;
  assign rspDrop = memRdValid && (pendDrop != '0);
  assign rspKeep = memRdValid && (pendDrop == '0);

  always_comb begin
    keepNext = pendKeep + PW'(accept) - PW'(rspKeep);
    dropNext = pendDrop - PW'(rspDrop);
    if (strb.flush) begin
      dropNext = dropNext + keepNext;
      keepNext = '0;
    end
  end

  always_comb begin
    if (!strb.firstRow) thisRow = rowPtr;
    else if (frmRotate) thisRow = frmBaseWord + LAST_ROWOF;
    else                thisRow = frmBaseWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowPtr    <= '0;
      curAddr   <= '0;
      wordsLeft <= '0;
      pendKeep  <= '0;
      pendDrop  <= '0;
    end else begin
      pendKeep <= keepNext;
      pendDrop <= dropNext;
      if (strb.flush) begin
        wordsLeft <= '0;
      end else if (strb.rowStart) begin
        wordsLeft <= ROW_WORDS;
        curAddr   <= frmRotate ? thisRow + LAST_COL : thisRow;
        rowPtr    <= frmRotate ? thisRow - STRIDE_W : thisRow + STRIDE_W;
      end else if (accept) begin
        wordsLeft <= wordsLeft - 1'b1;
        curAddr   <= frmRotate ? curAddr - 1'b1 : curAddr + 1'b1;
      end
    end
  end

  assign popNow = strb.pixPop && !fifoEmpty;

  fbscan_fifo #(.WIDTH(24), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(rspKeep), .wrData(memRdData[23:0]),
    .pop(popNow), .rdData(headPix), .count(fifoCnt), .empty(fifoEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) pixReg <= '0;
    else       pixReg <= popNow ? headPix : '0;
  end

  assign red   = pixReg[23:16];
  assign green = pixReg[15:8];
  assign blue  = pixReg[7:0];
endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int H_VIS = 640, H_FP = 16, H_SYNC = 96, H_BP = 48,
  parameter int V_VIS = 480, V_FP = 10, V_SYNC = 2,  V_BP = 33,
  parameter int ROW_STRIDE = 1024,
  parameter int WORD_AW = 30,
  parameter int BASE_BITS = 11,
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regSel,
  input  logic [31:0]        regWdata,
  output logic               memReq,
  output logic [WORD_AW-1:0] memAddr,
  input  logic               memReady,
  input  logic               memRdValid,
  input  logic [31:0]        memRdData,
  output logic               deOut,
  output logic               hsyncN,
  output logic               vsyncN,
  output logic [7:0]         red,
  output logic [7:0]         green,
  output logic [7:0]         blue
);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  fbscan_strobe_t     strb;
  logic [WORD_AW-1:0] frmBaseWord;
  logic               frmRotate;
  logic [CNTW-1:0]    fifoCnt;

  fbscan_ctrl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WORD_AW(WORD_AW), .BASE_BITS(BASE_BITS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strb(strb), .frmBaseWord(frmBaseWord), .frmRotate(frmRotate),
    .deOut(deOut), .hsyncN(hsyncN), .vsyncN(vsyncN)
  );

  fbscan_dp #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .ROW_STRIDE(ROW_STRIDE),
    .WORD_AW(WORD_AW), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .frmBaseWord(frmBaseWord),
    .frmRotate(frmRotate), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memRdValid(memRdValid), .memRdData(memRdData),
    .red(red), .green(green), .blue(blue), .fifoCnt(fifoCnt)
  );
endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk #(
  parameter int WORD_AW = 30,
  parameter int FIFO_DEPTH = 16,
  localparam int CNTW = $clog2(FIFO_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic               regSel,
  input logic               wrBit0,
  input logic               memReq,
  input logic               memReady,
  input logic [WORD_AW-1:0] memAddr,
  input logic               deOut,
  input logic               hsyncN,
  input logic               vsyncN,
  input logic [23:0]        pix,
  input logic [CNTW-1:0]    fifoCount
);
  localparam logic [CNTW-1:0] DEPTH_C = CNTW'(FIFO_DEPTH);

  p_black_in_blank_r4: assert property (@(posedge clk) disable iff (!rstN)
    !deOut |-> (pix == 24'd0));

  p_no_sync_in_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> (hsyncN && vsyncN));

  p_addr_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (!memReq || $stable(memAddr)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= DEPTH_C);

  p_off_stops_fetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel && !wrBit0) |=> ##1 !memReq);
endmodule

bind fbscan_top fbscan_chk #(.WORD_AW(WORD_AW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .wrBit0(regWdata[0]),
  .memReq(memReq), .memReady(memReady), .memAddr(memAddr),
  .deOut(deOut), .hsyncN(hsyncN), .vsyncN(vsyncN),
  .pix({red, green, blue}), .fifoCount(u_dp.fifoCnt)
);

// File: tb/fbscan_top_tb.sv
module fbscan_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HV = 8, HF = 4, HS = 6, HB = 14;
  localparam int VV = 4, VF = 1, VS = 2, VB = 2;
  localparam int STRIDE = 16;
  localparam int HBLANK = HF + HS + HB;
  localparam int HTOT = HBLANK + HV;
  localparam int VTOT = VV + VF + VS + VB;
  localparam int FTOT = HTOT * VTOT;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0, regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic memReq, memReady = 1'b0, memRdValid = 1'b0;
  logic [29:0] memAddr;
  logic [31:0] memRdData = '0;
  logic deOut, hsyncN, vsyncN;
  logic [7:0] red, green, blue;

  fbscan_top #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .ROW_STRIDE(STRIDE), .WORD_AW(30), .BASE_BITS(11), .FIFO_DEPTH(16)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .memReq(memReq), .memAddr(memAddr), .memReady(memReady),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .deOut(deOut), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .red(red), .green(green), .blue(blue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [31:0] pixWord(input logic [29:0] a);
    logic [7:0] lo, mid;
    lo = a[7:0];
    mid = a[15:8];
    return {lo ^ 8'h5A, lo + mid, ~lo, (lo * 8'd3) ^ 8'h21};
  endfunction

  function automatic logic [29:0] baseOf(input logic [31:0] d);
    return {d[31:21], 19'd0};
  endfunction

  function automatic logic [29:0] pixAddr(input logic [29:0] b, input bit rot, input int x, input int y);
    int px, py;
    px = rot ? HV - 1 - x : x;
    py = rot ? VV - 1 - y : y;
    return b + 30'(py * STRIDE + px);
  endfunction

  // shadow of the written registers and the per-frame model state
  bit shEn = 0, shRot = 0;
  logic [31:0] shBase = '0;
  bit mEn = 0, mRot = 0;
  logic [29:0] mBase = '0;
  int pos = 0, cyc = 0;
  bit started = 0;
  bit expDe = 0, expHs = 1, expVs = 1;
  logic [23:0] expRgb = '0;
  string rgbTag = "R4";

  always @(posedge clk) begin
    if (!rstN) begin
      pos = 0; mEn = 0; mRot = 0; mBase = '0; started = 0;
    end else begin
      int h, v;
      bit vis;
      h = pos % HTOT;
      v = pos / HTOT;
      vis = (h >= HBLANK) && (v < VV);
      expDe = vis;
      expHs = !((h >= HF) && (h < HF + HS));
      expVs = !((v >= VV + VF) && (v < VV + VF + VS));
      expRgb = (vis && mEn) ? pixWord(pixAddr(mBase, mRot, h - HBLANK, v))[23:0] : 24'd0;
      if (!vis) rgbTag = "R4";
      else if (!mEn) rgbTag = "R9";
      else if (mRot) rgbTag = "R7";
      else rgbTag = "R5";
      if (pos == FTOT - 1) begin
        mEn = shEn; mRot = shRot; mBase = baseOf(shBase);
      end else if (!shEn) begin
        mEn = 0;
      end
      pos = (pos + 1) % FTOT;
      cyc++;
      started = 1;
    end
  end

  // memory model plus output checks, away from the active edge
  logic [29:0] qAddr[$];
  int qDue[$];
  int lastDue = 0, nAcc = 0;
  bit prevHeld = 0;
  logic [29:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN && started && !finished) begin
      int h, v;
      h = pos % HTOT;
      v = pos / HTOT;
      check(deOut == expDe, "R4", 32'(deOut), 32'(expDe));
      check(hsyncN == expHs, "R2", 32'(hsyncN), 32'(expHs));
      check(vsyncN == expVs, "R3", 32'(vsyncN), 32'(expVs));
      check({red, green, blue} == expRgb, rgbTag, {8'd0, red, green, blue}, {8'd0, expRgb});
      if (!mEn) check(!memReq, "R10", 32'(memReq), 32'd0);
      if (prevHeld && memReq) check(memAddr == prevAddr, "R11", 32'(memAddr), 32'(prevAddr));
      if (h == 0) nAcc = 0;
      memReady = ($urandom % 4) != 0;
      prevHeld = memReq && !memReady;
      prevAddr = memAddr;
      if (memReq && memReady) begin
        logic [29:0] ea;
        int due;
        ea = pixAddr(mBase, mRot, nAcc, v);
        check((v < VV) && (h < HBLANK) && (nAcc < HV), "R12", 32'(h), 32'(HBLANK));
        check(memAddr == ea, (v == 0 && nAcc == 0) ? "R8" : (mRot ? "R7" : "R6"),
              32'(memAddr), 32'(ea));
        nAcc++;
        due = cyc + 2 + int'($urandom % 3);
        if (due <= lastDue) due = lastDue + 1;
        lastDue = due;
        qAddr.push_back(memAddr);
        qDue.push_back(due);
      end
      if (qAddr.size() > 0 && qDue[0] <= cyc) begin
        memRdValid = 1'b1;
        memRdData = pixWord(qAddr[0]);
        void'(qAddr.pop_front());
        void'(qDue.pop_front());
      end else begin
        memRdValid = 1'b0;
        memRdData = 32'hDEAD_0000;
      end
    end
  end

  task automatic regWrite(input bit sel, input logic [31:0] d);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(posedge clk);
    #1;
    if (sel) begin shEn = d[0]; shRot = d[1]; end
    else shBase = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    repeat (n * FTOT) @(negedge clk);
  endtask

  task automatic waitVisible();
    do @(negedge clk); while (!deOut);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(deOut == 1'b0, "R1", 32'(deOut), 32'd0);
    check(hsyncN == 1'b1, "R1", 32'(hsyncN), 32'd1);
    check(vsyncN == 1'b1, "R1", 32'(vsyncN), 32'd1);
    check({red, green, blue} == 24'd0, "R1", {8'd0, red, green, blue}, 32'd0);
    check(memReq == 1'b0, "R1", 32'(memReq), 32'd0);
    rstN = 1'b1;
    waitFrames(1);
    // R8: base with low bits set, then enable
    regWrite(1'b0, 32'h1234_5678);
    regWrite(1'b1, 32'h0000_0001);
    waitFrames(3);
    // R7, R9: rotate and new base written mid-row
    waitVisible();
    regWrite(1'b1, 32'hFFFF_FFF3);
    regWrite(1'b0, 32'hA9FF_FFFF);
    waitFrames(3);
    // R9, R10: disable mid-row, re-enable mid-frame
    waitVisible();
    regWrite(1'b1, 32'h0000_0000);
    waitFrames(1);
    waitVisible();
    regWrite(1'b1, 32'h0000_0001);
    waitFrames(3);
    for (int i = 0; i < 6; i++) begin
      repeat (int'($urandom % FTOT)) @(negedge clk);
      if ($urandom % 2) regWrite(1'b1, 32'($urandom % 4) | 32'h1);
      else regWrite(1'b0, $urandom);
      if (i == 3) regWrite(1'b1, 32'h0000_0002);
      waitFrames(2);
    end
    regWrite(1'b1, 32'h0000_0001);
    waitFrames(2);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end
endmodule